// File: doc/BRIEF.md
# Instruction-Fetch Guard with Lockable No-Execute Window

This block watches every CPU bus access (address, valid strobe and an instruction-fetch flag) and raises a trap output as soon as it sees a forbidden access. Two checks are always on. The first flags any instruction fetch from the firmware scratch RAM. The second flags any access to the RAM address range that lies past the RAM that is physically present.

A third check is set up by the running application. Through a small register port, software writes a lower and an upper bound, then sets an arm bit. From that cycle on, instruction fetches that fall inside the window are flagged. Arming is one-way: the arm bit cannot be cleared, and the bounds no longer take writes. The bounds must therefore be written before the arm bit.

The trap output is sticky and stays high until reset. The region bounds and the RAM size are parameters.

Top module: `exec_guard`

## Requirements
- R1: After reset, trap is 0, the window is not armed, and both bounds read as 0.
- R2: A valid instruction fetch with FW_LO <= addr <= FW_HI sets trap at the next clock edge, whatever the register state. A data access (fetch flag 0) in that range does not set trap.
- R3: Any valid access, fetch or data, with RAM_BASE + RAM_BYTES <= addr < RAM_BASE + RAM_SPAN sets trap at the next edge. Accesses below RAM_BASE + RAM_BYTES, or at or above RAM_BASE + RAM_SPAN, do not.
- R4: The register port decodes three offsets. Offset 0x60 is control, with bit 0 as the arm bit. Offset 0x61 is the lower bound and offset 0x62 is the upper bound. A write takes effect at the clock edge. reg_rdata is combinational from reg_off: the arm bit appears in bit 0 and the bounds appear in full. Any other offset reads 0.
- R5: While armed, a valid fetch with lower <= addr <= upper (inclusive at both ends) sets trap at the next edge. Fetches one below the lower bound or one above the upper bound do not.
- R6: Data accesses inside the armed window never set trap.
- R7: While not armed, fetches inside the programmed window do not set trap.
- R8: Once armed, writing 0 to control leaves the window armed, and writes to the lower and upper bounds are ignored. Both effects are visible through read-back and through trap behaviour.
- R9: Once set, trap stays at 1 through idle and harmless cycles until rst_n is asserted.
- R10: Bus cycles with bus_valid at 0 never set trap, whatever the address and fetch flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | CPU access strobe |
| bus_instr | input | 1 | 1 when the access is an instruction fetch |
| bus_addr | input | AW | CPU byte address |
| reg_sel | input | 1 | Register port select |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_off | input | 8 | Register offset |
| reg_wdata | input | AW | Register write data |
| reg_rdata | output | AW | Register read data (combinational) |
| trap | output | 1 | Sticky violation flag |

## Verification
Trap is a single register, so an offending strobe presented during cycle k shows on trap after edge k. The bench drives each strobe for exactly one cycle on a falling edge and samples trap on the next falling edge. Register writes likewise take effect at the edge that captures them, so an arm write followed on the very next cycle by a window fetch is already checked against the armed window. Read-back is combinational and is sampled shortly after the offset is driven, within the same low phase.

// File: rtl/exec_guard.sv
module exec_guard #(
  parameter int AW = 32,
  parameter logic [AW-1:0] FW_LO     = 32'hD000_0000,
  parameter logic [AW-1:0] FW_HI     = 32'hD000_07FF,
  parameter logic [AW-1:0] RAM_BASE  = 32'h4000_0000,
  parameter logic [AW-1:0] RAM_BYTES = 32'h0002_0000,
  parameter logic [AW-1:0] RAM_SPAN  = 32'h0100_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_valid,
  input  logic          bus_instr,
  input  logic [AW-1:0] bus_addr,
  input  logic          reg_sel,
  input  logic          reg_wr,
  input  logic [7:0]    reg_off,
  input  logic [AW-1:0] reg_wdata,
  output logic [AW-1:0] reg_rdata,
  output logic          trap
);

  localparam logic [7:0] OFF_CTRL = 8'h60;
  localparam logic [7:0] OFF_LO   = 8'h61;
  localparam logic [7:0] OFF_HI   = 8'h62;
  localparam logic [AW:0] PHYS_END = {1'b0, RAM_BASE} + {1'b0, RAM_BYTES};
  localparam logic [AW:0] DEC_END  = {1'b0, RAM_BASE} + {1'b0, RAM_SPAN};

  logic          armed;
  logic [AW-1:0] win_lo, win_hi;
  logic          fw_hit, oob_hit, win_hit;
  logic          wr_ctrl, wr_lo, wr_hi;
  logic [AW:0]   addr_x;

  assign addr_x  = {1'b0, bus_addr};
  assign wr_ctrl = reg_sel && reg_wr && (reg_off == OFF_CTRL);
  assign wr_lo   = reg_sel && reg_wr && (reg_off == OFF_LO) && !armed;
  assign wr_hi   = reg_sel && reg_wr && (reg_off == OFF_HI) && !armed;

  assign fw_hit  = bus_valid && bus_instr && (bus_addr >= FW_LO) && (bus_addr <= FW_HI);
  assign oob_hit = bus_valid && (addr_x >= PHYS_END) && (addr_x < DEC_END);
  assign win_hit = bus_valid && bus_instr && armed &&
                   (bus_addr >= win_lo) && (bus_addr <= win_hi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      win_lo <= '0;
      win_hi <= '0;
    end else begin
      if (wr_ctrl) armed  <= armed | reg_wdata[0];
      if (wr_lo)   win_lo <= reg_wdata;
      if (wr_hi)   win_hi <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trap <= 1'b0;
    else if (fw_hit || oob_hit || win_hit) trap <= 1'b1;
  end

  always_comb begin
    case (reg_off)
      OFF_CTRL: reg_rdata = {{(AW-1){1'b0}}, armed};
      OFF_LO:   reg_rdata = win_lo;
      OFF_HI:   reg_rdata = win_hi;
      default:  reg_rdata = '0;
    endcase
  end

  p_fw_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fw_hit |=> trap);
  p_beyond_ram_r3: assert property (@(posedge clk) disable iff (!rst_n)
    oob_hit |=> trap);
  p_window_fetch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    win_hit |=> trap);
  p_arm_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> armed);
  p_bounds_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> ($stable(win_lo) && $stable(win_hi)));
  p_trap_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    trap |=> trap);
  p_trap_has_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trap) |-> $past(bus_valid));

endmodule

// File: tb/sim_exec_guard.sv
module sim_exec_guard;
  localparam int AW = 32;
  localparam logic [31:0] FW_LO     = 32'hD000_0000;
  localparam logic [31:0] FW_HI     = 32'hD000_07FF;
  localparam logic [31:0] RAM_BASE  = 32'h4000_0000;
  localparam logic [31:0] RAM_BYTES = 32'h0002_0000;
  localparam logic [31:0] RAM_SPAN  = 32'h0100_0000;
  localparam logic [31:0] WLO = 32'h4000_1000;
  localparam logic [31:0] WHI = 32'h4000_10FF;

  // {arm window, fetch flag, expected trap, address}
  localparam logic [34:0] VEC [0:12] = '{
    {1'b0, 1'b1, 1'b1, FW_LO},                        // R2
    {1'b0, 1'b1, 1'b1, FW_HI},                        // R2
    {1'b0, 1'b0, 1'b0, FW_LO + 32'd4},                // R2 data ok
    {1'b0, 1'b0, 1'b1, RAM_BASE + RAM_BYTES},         // R3
    {1'b0, 1'b1, 1'b0, RAM_BASE + RAM_BYTES - 32'd4}, // R3 inside
    {1'b0, 1'b0, 1'b1, RAM_BASE + RAM_SPAN - 32'd1},  // R3
    {1'b0, 1'b0, 1'b0, RAM_BASE + RAM_SPAN},          // R3 past region
    {1'b1, 1'b1, 1'b1, WLO},                          // R5
    {1'b1, 1'b1, 1'b1, WHI},                          // R5
    {1'b1, 1'b1, 1'b0, WLO - 32'd1},                  // R5
    {1'b1, 1'b1, 1'b0, WHI + 32'd1},                  // R5
    {1'b1, 1'b0, 1'b0, WLO + 32'd8},                  // R6
    {1'b0, 1'b1, 1'b0, WLO}                           // R7
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_instr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic reg_sel = 1'b0, reg_wr = 1'b0;
  logic [7:0] reg_off = '0;
  logic [AW-1:0] reg_wdata = '0;
  logic [AW-1:0] reg_rdata;
  logic trap;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  exec_guard #(.AW(AW), .FW_LO(FW_LO), .FW_HI(FW_HI), .RAM_BASE(RAM_BASE),
               .RAM_BYTES(RAM_BYTES), .RAM_SPAN(RAM_SPAN)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_instr(bus_instr),
    .bus_addr(bus_addr), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_off(reg_off),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .trap(trap));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
  endtask

  task automatic wr(logic [7:0] off, logic [31:0] d);
    @(negedge clk) begin reg_sel = 1'b1; reg_wr = 1'b1; reg_off = off; reg_wdata = d; end
    @(negedge clk) begin reg_sel = 1'b0; reg_wr = 1'b0; end
  endtask

  task automatic rd(logic [7:0] off, output logic [31:0] d);
    @(negedge clk) begin reg_sel = 1'b1; reg_wr = 1'b0; reg_off = off; end
    #1 d = reg_rdata;
  endtask

  task automatic access(logic v, logic ins, logic [31:0] a);
    @(negedge clk) begin bus_valid = v; bus_instr = ins; bus_addr = a; end
    @(negedge clk) begin bus_valid = 1'b0; bus_instr = 1'b0; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    do_reset();
    check("R1 trap", {31'd0, trap}, 32'd0);
    rd(8'h60, d); check("R1 ctrl", d, 32'd0);
    rd(8'h61, d); check("R1 lo", d, 32'd0);
    rd(8'h62, d); check("R1 hi", d, 32'd0);

    for (int i = 0; i < 13; i++) begin
      do_reset();
      wr(8'h61, WLO);
      wr(8'h62, WHI);
      if (VEC[i][34]) wr(8'h60, 32'd1);
      access(1'b1, VEC[i][33], VEC[i][31:0]);
      check($sformatf("vector %0d (R2/R3/R5/R6/R7)", i), {31'd0, trap}, {31'd0, VEC[i][32]});
    end

    // R4 read-back and unmapped offset
    do_reset();
    wr(8'h61, 32'h1234_5678);
    wr(8'h62, 32'h9ABC_DEF0);
    rd(8'h61, d); check("R4 lo", d, 32'h1234_5678);
    rd(8'h62, d); check("R4 hi", d, 32'h9ABC_DEF0);
    rd(8'h63, d); check("R4 unmapped", d, 32'd0);
    wr(8'h60, 32'd1);
    rd(8'h60, d); check("R4 armed bit", d, 32'd1);

    // R8 lock after arming
    wr(8'h60, 32'd0);
    wr(8'h61, 32'h0);
    wr(8'h62, 32'hFFFF_FFFF);
    rd(8'h60, d); check("R8 arm held", d, 32'd1);
    rd(8'h61, d); check("R8 lo frozen", d, 32'h1234_5678);
    rd(8'h62, d); check("R8 hi frozen", d, 32'h9ABC_DEF0);
    @(negedge clk) reg_sel = 1'b0;
    access(1'b1, 1'b1, 32'h0000_0100);
    check("R8 no trap below frozen lo", {31'd0, trap}, 32'd0);
    access(1'b1, 1'b1, 32'h1234_5678);
    check("R8 window still armed", {31'd0, trap}, 32'd1);

    // R10 valid low ignored
    do_reset();
    access(1'b0, 1'b1, FW_LO);
    access(1'b0, 1'b0, RAM_BASE + RAM_BYTES);
    check("R10 no strobe", {31'd0, trap}, 32'd0);

    // R9 sticky
    access(1'b1, 1'b1, FW_LO);
    repeat (5) access(1'b1, 1'b0, RAM_BASE);
    check("R9 sticky", {31'd0, trap}, 32'd1);
    do_reset();
    check("R9 cleared by reset", {31'd0, trap}, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule